// File: doc/BRIEF.md
# Session Seed Entropy Mixer

The block produces a fresh 64-bit seed for every cryptographic session. It takes a seed from external non-volatile storage, which an attacker could replay. It combines that seed with entropy gathered on chip, so that a replayed external value still yields a new result. Several free-running oscillator bits arrive as asynchronous inputs. Each bit passes through its own two-stage synchronizer. The synchronized bits are XOR-combined and folded into a 64-bit Galois LFSR that runs on the system clock.

Entropy is taken only during one fixed window right after reset. After that window the accumulator no longer listens to the oscillators, so slow coupling between the oscillators and the clock cannot erode the sample. Each seed request advances the LFSR by a fixed number of extra steps. A session counter kept in on-chip registers is folded into every output. Together these keep seeds distinct across sessions within one power cycle.

Top module: `seed_mixer`

## Requirements
- R1: Each entropy input passes through two flip-flops clocked by `clk`. The XOR of all synchronized bits is injected into bit 63 of the accumulator on every capture-window step. The value applied to an input at one clock edge therefore reaches the accumulator at the second following edge, and different entropy streams give different seeds.
- R2: After reset is released, the capture window lasts exactly CAPTURE_CYCLES clock edges. `ready` is low during the window, rises at its end and stays high until the next reset.
- R3: Once `ready` is high, the entropy inputs have no effect on any later seed.
- R4: The accumulator resets to 64'h9E3779B97F4A7C15. Each step shifts it right by one bit and XORs 64'hD800000000000000 into it when the bit shifted out was 1; during capture the entropy bit is then XORed into bit 63. A step whose result is all zero loads the reset constant instead.
- R5: A `seedReq` seen while `ready` is low sets `earlyReq`, which stays high until reset. Such a request produces no seed.
- R6: A `seedReq` seen while idle and ready starts ADVANCE_STEPS accumulator steps with no entropy. `seedValid` pulses high for exactly one cycle, ADVANCE_STEPS edges after the request edge.
- R7: `seedOut` equals the accumulator value after the last advance step, XOR the latched external seed, XOR the session counter. The session counter is 0 after reset and increases by 1 after each seed.
- R8: `extSeed` is latched on every edge where `extValid` is high. Seeds use the latched value, which reset sets to zero.
- R9: A `seedReq` that arrives while an advance is running is ignored.
- R10: Two consecutive requests with the same external seed give different seeds.
- R11: `seedOut` holds its value between `seedValid` pulses, and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| entropyIn | input | NUM_SRC | Asynchronous oscillator bits |
| extSeed | input | 64 | Seed from external storage |
| extValid | input | 1 | Latches `extSeed` |
| seedReq | input | 1 | Request for a new session seed |
| seedOut | output | 64 | Session seed |
| seedValid | output | 1 | One-cycle strobe marking a new `seedOut` |
| ready | output | 1 | Capture window finished |
| earlyReq | output | 1 | Sticky flag: a request came before `ready` |

## Verification
The accumulator is not visible at the ports, so a wrong step, a misplaced injection bit or a broken zero guard shows only in the next `seedOut`. That means at least one advance run of ADVANCE_STEPS cycles after the fault. The bench therefore compares every seed bit for bit against a behavioural model that follows the same entropy stream. A wrong window length or a wrong advance count shows sooner, as a misplaced edge of `ready` or `seedValid`, and the per-cycle comparison catches it on the very cycle it occurs.

// File: rtl/seed_mixer_pkg.sv
package seed_mixer_pkg;
  localparam int SEED_W = 64;
  // Galois mask for x^64 + x^63 + x^61 + x^60 + 1, right-shifting form
  localparam logic [SEED_W-1:0] TAP_MASK  = 64'hD800_0000_0000_0000;
  localparam logic [SEED_W-1:0] LFSR_INIT = 64'h9E37_79B9_7F4A_7C15;

  typedef struct packed {
    logic absorb;   // step accumulator with entropy injection
    logic advance;  // step accumulator without entropy
    logic emit;     // last advance step: publish a seed
  } mixStrobes_t;
endpackage

// File: rtl/seed_sync.sv
module seed_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/seed_mixer_ctrl.sv
module seed_mixer_ctrl
  import seed_mixer_pkg::*;
#(
  parameter int CAPTURE_CYCLES = 128,
  parameter int ADVANCE_STEPS  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedReq,
  output mixStrobes_t strobes,
  output logic        ready,
  output logic        earlyReq
);
  localparam int MAX_CNT = (CAPTURE_CYCLES > ADVANCE_STEPS) ? CAPTURE_CYCLES : ADVANCE_STEPS;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;
  localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CAPTURE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ADV_LAST = CNT_W'(ADVANCE_STEPS - 1);

  typedef enum logic [1:0] {CAPTURE, IDLE, ADVANCE} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= CAPTURE;
      count    <= '0;
      earlyReq <= 1'b0;
    end else begin
      unique case (state)
        CAPTURE: begin
          if (seedReq) earlyReq <= 1'b1;
          if (count == CAP_LAST) begin
            state <= IDLE;
            count <= '0;
          end else begin
            count <= count + 1'b1;
          end
        end
        IDLE: begin
          if (seedReq) begin
            state <= ADVANCE;
            count <= '0;
          end
        end
        ADVANCE: begin
          if (count == ADV_LAST) begin
            state <= IDLE;
            count <= '0;
          end else begin
            count <= count + 1'b1;
          end
        end
        default: state <= CAPTURE;
      endcase
    end
  end

  always_comb begin
    strobes.absorb  = (state == CAPTURE);
    strobes.advance = (state == ADVANCE);
    strobes.emit    = (state == ADVANCE) && (count == ADV_LAST);
  end

  assign ready = (state != CAPTURE);
endmodule

// File: rtl/seed_mixer_dp.sv
module seed_mixer_dp
  import seed_mixer_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] entropyIn,
  input  logic [SEED_W-1:0] extSeed,
  input  logic              extValid,
  input  mixStrobes_t       strobes,
  output logic [SEED_W-1:0] seedOut,
  output logic              seedValid
);
  logic [NUM_SRC-1:0] syncBits;
  logic               mixBit;
  logic [SEED_W-1:0]  lfsr, lfsrNext, extReg, sessCount;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    seed_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .d    (entropyIn[g]),
      .q    (syncBits[g])
    );
  end

  assign mixBit = ^syncBits;

  always_comb begin
    lfsrNext = {1'b0, lfsr[SEED_W-1:1]} ^ (lfsr[0] ? TAP_MASK : '0);
    lfsrNext[SEED_W-1] = lfsrNext[SEED_W-1] ^ (strobes.absorb & mixBit);
    if (lfsrNext == '0) lfsrNext = LFSR_INIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr      <= LFSR_INIT;
      extReg    <= '0;
      sessCount <= '0;
      seedOut   <= '0;
      seedValid <= 1'b0;
    end else begin
      if (strobes.absorb || strobes.advance) lfsr <= lfsrNext;
      if (extValid) extReg <= extSeed;
      seedValid <= strobes.emit;
      if (strobes.emit) begin
        seedOut   <= lfsrNext ^ extReg ^ sessCount;
        sessCount <= sessCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seed_mixer.sv
module seed_mixer
  import seed_mixer_pkg::*;
#(
  parameter int NUM_SRC        = 4,
  parameter int CAPTURE_CYCLES = 128,
  parameter int ADVANCE_STEPS  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] entropyIn,
  input  logic [63:0]        extSeed,
  input  logic               extValid,
  input  logic               seedReq,
  output logic [63:0]        seedOut,
  output logic               seedValid,
  output logic               ready,
  output logic               earlyReq
);
  mixStrobes_t strobes;

  seed_mixer_ctrl #(
    .CAPTURE_CYCLES (CAPTURE_CYCLES),
    .ADVANCE_STEPS  (ADVANCE_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seedReq  (seedReq),
    .strobes  (strobes),
    .ready    (ready),
    .earlyReq (earlyReq)
  );

  seed_mixer_dp #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .entropyIn (entropyIn),
    .extSeed   (extSeed),
    .extValid  (extValid),
    .strobes   (strobes),
    .seedOut   (seedOut),
    .seedValid (seedValid)
  );
endmodule

// File: rtl/seed_mixer_checker.sv
module seed_mixer_checker (
  input logic        clk,
  input logic        rstN,
  input logic        seedReq,
  input logic [63:0] seedOut,
  input logic        seedValid,
  input logic        ready,
  input logic        earlyReq
);
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  a_r5_early_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (seedReq && !ready) |=> earlyReq);

  a_r5_early_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    earlyReq |=> earlyReq);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    seedValid |=> !seedValid);

  a_r5_no_seed_before_ready: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !seedValid);

  a_r11_out_held: assert property (@(posedge clk) disable iff (!rstN)
    !seedValid |-> $stable(seedOut));
endmodule

bind seed_mixer seed_mixer_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .seedReq   (seedReq),
  .seedOut   (seedOut),
  .seedValid (seedValid),
  .ready     (ready),
  .earlyReq  (earlyReq)
);

// File: tb/test_seed_mixer.sv
`timescale 1ns/1ps
module test_seed_mixer;
  localparam int NSRC = 4;
  localparam int CAP  = 128;
  localparam int ADV  = 64;
  localparam logic [63:0] MASK = 64'hD800_0000_0000_0000;
  localparam logic [63:0] INIT = 64'h9E37_79B9_7F4A_7C15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] entropyIn = '0;
  logic [63:0] extSeed = '0;
  logic extValid = 1'b0;
  logic seedReq = 1'b0;
  logic [63:0] seedOut;
  logic seedValid, ready, earlyReq;

  always #2.5 clk = ~clk;

  seed_mixer #(.NUM_SRC(NSRC), .CAPTURE_CYCLES(CAP), .ADVANCE_STEPS(ADV)) i_seed_mixer (
    .clk(clk), .rstN(rstN), .entropyIn(entropyIn), .extSeed(extSeed),
    .extValid(extValid), .seedReq(seedReq), .seedOut(seedOut),
    .seedValid(seedValid), .ready(ready), .earlyReq(earlyReq));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int entMode = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic logic [63:0] step(logic [63:0] v, logic inj);
    logic [63:0] n;
    n = v >> 1;
    if (v[0]) n = n ^ MASK;
    n[63] = n[63] ^ inj;
    if (n == 64'd0) n = INIT;
    return n;
  endfunction

  logic [NSRC-1:0] pipeQ[$];
  int mState = 0, mCnt = 0;
  logic [63:0] mLfsr = INIT, mExt = '0, mSess = '0, mOut = '0;
  logic mValid = 1'b0, mErr = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ = '{'0, '0};
      mState = 0; mCnt = 0; mLfsr = INIT; mExt = '0; mSess = '0;
      mOut = '0; mValid = 1'b0; mErr = 1'b0;
    end else begin
      logic mix;
      mix = ^pipeQ[0];
      void'(pipeQ.pop_front());
      pipeQ.push_back(entropyIn);
      mValid = 1'b0;
      case (mState)
        0: begin
          mLfsr = step(mLfsr, mix);
          if (seedReq) mErr = 1'b1;
          if (mCnt == CAP - 1) begin mState = 1; mCnt = 0; end
          else mCnt++;
        end
        1: if (seedReq) begin mState = 2; mCnt = 0; end
        default: begin
          mLfsr = step(mLfsr, 1'b0);
          if (mCnt == ADV - 1) begin
            mOut = mLfsr ^ mExt ^ mSess;
            mSess = mSess + 1;
            mValid = 1'b1;
            mState = 1; mCnt = 0;
          end else mCnt++;
        end
      endcase
      if (extValid) mExt = extSeed;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 ready", {63'd0, ready}, {63'd0, mState != 0});
      chk("R5 earlyReq", {63'd0, earlyReq}, {63'd0, mErr});
      chk("R6 seedValid", {63'd0, seedValid}, {63'd0, mValid});
      chk("R7 seedOut", seedOut, mOut);
    end
  end

  // entropy drivers (R1, R3): changed only at negedge
  always @(negedge clk) begin
    case (entMode)
      0: entropyIn <= '0;
      1: entropyIn <= NSRC'($urandom);
      default: entropyIn <= ~entropyIn ^ NSRC'(1);
    endcase
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish();
    end
  end

  task automatic finish();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic doReset(int mode);
    @(negedge clk);
    entMode = mode;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset seedOut", seedOut, 64'd0);
    chk("R2 reset ready", {63'd0, ready}, 64'd0);
    rstN = 1'b1;
  endtask

  task automatic loadExt(logic [63:0] v);
    @(negedge clk);
    extSeed = v; extValid = 1'b1;
    @(negedge clk);
    extValid = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    seedReq = 1'b1;
    @(negedge clk);
    seedReq = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < CAP + 10 && !ready; i++) @(negedge clk);
  endtask

  task automatic getSeed(output logic [63:0] s, output int pulses, input bit midReq);
    pulses = 0;
    pulseReq();
    for (int i = 0; i < ADV + 8; i++) begin
      if (midReq && i == 10) seedReq = 1'b1;
      if (midReq && i == 11) seedReq = 1'b0;
      @(negedge clk);
      if (seedValid) begin pulses++; s = seedOut; end
    end
  endtask

  logic [63:0] s1, s2, s3, s4, held;
  int np;

  initial begin
    // run 1: zero entropy, early request
    doReset(0);
    repeat (5) @(negedge clk);
    pulseReq();                                  // R5: before ready
    waitReady();
    chk("R5 early flag", {63'd0, earlyReq}, 64'd1);
    loadExt(64'hA5A5_0F0F_1234_5678);
    getSeed(s1, np, 1'b0);
    chk("R6 one pulse", np, 1);
    getSeed(s2, np, 1'b1);                       // R9: mid-advance request ignored
    chk("R9 single pulse despite mid request", np, 1);
    chk("R10 replayed ext gives new seed", {63'd0, s1 != s2}, 64'd1);
    repeat (20) @(negedge clk);
    held = seedOut;
    chk("R11 seed held", held, s2);

    // run 2: random entropy, continues after ready (R3)
    doReset(1);
    waitReady();
    chk("R5 no early flag", {63'd0, earlyReq}, 64'd0);
    loadExt(64'hA5A5_0F0F_1234_5678);
    getSeed(s3, np, 1'b0);
    chk("R1 entropy changes first seed", {63'd0, s1 != s3}, 64'd1);
    loadExt(64'h0000_0000_0000_0001);            // R8: new external value
    getSeed(s4, np, 1'b0);
    chk("R8 new ext yields pulse", np, 1);

    // run 3: toggling pattern entropy, R4 zero guard covered by the model
    doReset(2);
    waitReady();
    loadExt(64'hFFFF_FFFF_FFFF_FFFF);
    getSeed(s4, np, 1'b0);
    chk("R4 seed from toggled entropy", {63'd0, s4 != s3}, 64'd1);
    repeat (5) @(negedge clk);
    finish();
  end
endmodule